// File: doc/BRIEF.md
# Disjoint-Mask Warp Co-Issue Finder

This block is the second stage of a cascaded warp scheduler. The upstream scheduler has already chosen a primary warp and supplies that warp's active-lane mask. The block then searches for a second warp that can share the same issue slot. The second warp must occupy only the vector lanes that the primary warp leaves idle. When one is found, both warps issue together, and the lanes show which warp drives each of them.

The block holds one active-lane mask per warp. A mask is written in logical thread order and stored in physical lane order. Each warp has a fixed lane rotation equal to its index modulo the lane count. Because of this rotation, threads with the same index in neighbouring warps land on different physical lanes, and warps with similar divergence patterns collide less often. The warps are split into groups of consecutive indices. Only the group that contains the primary warp is searched, so the compare logic is one group wide and does not span every warp. A stored zero bit means an idle lane: only the lanes the primary warp uses must be free in the candidate.

Results are registered and appear one clock after the request.

Top module: `cif_coissue_finder`

## Requirements
- R1: While reset is asserted and after its release with no request, `issue_valid_o`, `sec_valid_o`, `sec_wid_o`, `lane_en_o` and `lane_src_o` are all zero.
- R2: A warp's physical mask is its logical mask rotated up by (warp index mod LANES): logical thread t maps to physical lane (t + w) mod LANES. This rule applies to the primary mask and to the stored masks. Bit i of a mask vector is thread i or lane i.
- R3: A candidate is compatible only when the bitwise AND of its physical mask with the primary's physical mask is zero.
- R4: Only the warps in the primary's group are candidates. Warp w is in group w / WAYS, with WAYS = 4 by default.
- R5: A candidate must have its `ready_i` bit set and must differ from the primary warp.
- R6: When several candidates qualify, the one with the lowest warp index is chosen.
- R7: When no candidate qualifies, `sec_valid_o` is 0, `sec_wid_o` is 0, `lane_src_o` is 0, and `lane_en_o` holds the primary's physical mask alone.
- R8: When a candidate is found, `lane_en_o` is the OR of both physical masks. `lane_src_o` is 1 on exactly the secondary warp's lanes, and `issue_valid_o` is 1.
- R9: A mask written in a given cycle is used by searches from the next cycle on. A search in the same cycle uses the previous mask.
- R10: One cycle after a cycle with `prim_valid_i` low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Store a warp's active mask |
| wr_wid_i | input | $clog2(WARPS) | Warp whose mask is written |
| wr_mask_i | input | LANES | Logical active mask to store |
| ready_i | input | WARPS | Per-warp ready flags |
| prim_valid_i | input | 1 | Primary warp request present |
| prim_wid_i | input | $clog2(WARPS) | Primary warp index |
| prim_mask_i | input | LANES | Primary warp logical active mask |
| issue_valid_o | output | 1 | Primary warp issues this slot |
| sec_valid_o | output | 1 | A secondary warp co-issues |
| sec_wid_o | output | $clog2(WARPS) | Secondary warp index |
| lane_en_o | output | LANES | Merged physical lane enables |
| lane_src_o | output | LANES | 1 where the lane belongs to the secondary warp |

## Verification
The search is driven with several patterns. A clean disjoint pair separates pairing from no pairing. A mask that overlaps on a single lane tests the AND compare. Two warps with the same logical mask pair only because their rotations differ, which tests the permutation. A compatible warp placed in a different group tests the group restriction. An idle warp that is not ready, and a primary whose own stored mask would match, test the ready and self exclusions. Three equal candidates in one group fix the priority order. A mask write issued in the same cycle as a search shows which stored value that search sees.

// File: rtl/cif_pkg.sv
package cif_pkg;
  // Modular lane arithmetic shared by the rotation logic.
  function automatic int wrap_add(input int a, input int b, input int n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/cif_lane_rotate.sv
module cif_lane_rotate #(
  parameter int LANES = 16,
  parameter int WARPS = 16,
  localparam int WID_W  = $clog2(WARPS),
  localparam int LIDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask_i,
  input  logic [WID_W-1:0] wid_i,
  output logic [LANES-1:0] mask_o
);
  // thread t of warp w drives physical lane (t + w) mod LANES
  always_comb begin
    mask_o = '0;
    for (int t = 0; t < LANES; t++) begin
      logic [LIDX_W-1:0] lane;
      lane = LIDX_W'(cif_pkg::wrap_add(t, int'(wid_i) % LANES, LANES));
      mask_o[lane] = mask_i[t];
    end
  end
endmodule

// File: rtl/cif_mask_store.sv
module cif_mask_store #(
  parameter int WARPS = 16,
  parameter int LANES = 16,
  localparam int WID_W = $clog2(WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [WID_W-1:0]       wr_wid_i,
  input  logic [LANES-1:0]       wr_mask_i,
  output logic [WARPS*LANES-1:0] phys_masks_o
);
  logic [LANES-1:0] wr_phys;

  cif_lane_rotate #(.LANES(LANES), .WARPS(WARPS)) u_wr_rot (
    .mask_i (wr_mask_i),
    .wid_i  (wr_wid_i),
    .mask_o (wr_phys)
  );

  for (genvar w = 0; w < WARPS; w++) begin : g_entry
    logic             ce;
    logic [LANES-1:0] q;
    assign ce = wr_en_i && (wr_wid_i == WID_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= wr_phys;
    end
    assign phys_masks_o[w*LANES +: LANES] = q;
  end
endmodule

// File: rtl/cif_set_search.sv
module cif_set_search #(
  parameter int WARPS = 16,
  parameter int LANES = 16,
  parameter int WAYS  = 4,
  localparam int WID_W    = $clog2(WARPS),
  localparam int SET_BITS = $clog2(WAYS)
) (
  input  logic [WARPS*LANES-1:0] phys_masks_i,
  input  logic [WARPS-1:0]       ready_i,
  input  logic [WID_W-1:0]       prim_wid_i,
  input  logic [LANES-1:0]       prim_phys_i,
  output logic                   hit_o,
  output logic [WID_W-1:0]       hit_wid_o,
  output logic [LANES-1:0]       hit_mask_o
);
  logic [WAYS-1:0]        compat;
  logic [WID_W-1:0]       cand  [WAYS];
  logic [LANES-1:0]       cmask [WAYS];

  // one comparator per way of the primary's group
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign cand[w]   = {prim_wid_i[WID_W-1:SET_BITS], SET_BITS'(w)};
    assign cmask[w]  = phys_masks_i[cand[w]*LANES +: LANES];
    assign compat[w] = ready_i[cand[w]] && (cand[w] != prim_wid_i) &&
                       ((cmask[w] & prim_phys_i) == '0);
  end

  // lowest way, hence lowest warp index, wins
  always_comb begin
    hit_o      = 1'b0;
    hit_wid_o  = '0;
    hit_mask_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (compat[w]) begin
        hit_o      = 1'b1;
        hit_wid_o  = cand[w];
        hit_mask_o = cmask[w];
      end
    end
  end
endmodule

// File: rtl/cif_coissue_finder.sv
module cif_coissue_finder #(
  parameter int WARPS = 16,
  parameter int LANES = 16,
  parameter int WAYS  = 4,
  localparam int WID_W = $clog2(WARPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [WID_W-1:0] wr_wid_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic [WARPS-1:0] ready_i,
  input  logic             prim_valid_i,
  input  logic [WID_W-1:0] prim_wid_i,
  input  logic [LANES-1:0] prim_mask_i,
  output logic             issue_valid_o,
  output logic             sec_valid_o,
  output logic [WID_W-1:0] sec_wid_o,
  output logic [LANES-1:0] lane_en_o,
  output logic [LANES-1:0] lane_src_o
);
  logic [WARPS*LANES-1:0] phys_masks;
  logic [LANES-1:0]       prim_phys;
  logic                   hit;
  logic [WID_W-1:0]       hit_wid;
  logic [LANES-1:0]       hit_mask;

  logic             issue_n, sec_n;
  logic [WID_W-1:0] wid_n;
  logic [LANES-1:0] en_n, src_n;

  cif_mask_store #(.WARPS(WARPS), .LANES(LANES)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_wid_i     (wr_wid_i),
    .wr_mask_i    (wr_mask_i),
    .phys_masks_o (phys_masks)
  );

  cif_lane_rotate #(.LANES(LANES), .WARPS(WARPS)) u_prim_rot (
    .mask_i (prim_mask_i),
    .wid_i  (prim_wid_i),
    .mask_o (prim_phys)
  );

  cif_set_search #(.WARPS(WARPS), .LANES(LANES), .WAYS(WAYS)) u_search (
    .phys_masks_i (phys_masks),
    .ready_i      (ready_i),
    .prim_wid_i   (prim_wid_i),
    .prim_phys_i  (prim_phys),
    .hit_o        (hit),
    .hit_wid_o    (hit_wid),
    .hit_mask_o   (hit_mask)
  );

  always_comb begin
    issue_n = prim_valid_i;
    sec_n   = prim_valid_i && hit;
    wid_n   = sec_n ? hit_wid : '0;
    src_n   = sec_n ? hit_mask : '0;
    en_n    = prim_valid_i ? (prim_phys | src_n) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid_o <= 1'b0;
      sec_valid_o   <= 1'b0;
      sec_wid_o     <= '0;
      lane_en_o     <= '0;
      lane_src_o    <= '0;
    end else begin
      issue_valid_o <= issue_n;
      sec_valid_o   <= sec_n;
      sec_wid_o     <= wid_n;
      lane_en_o     <= en_n;
      lane_src_o    <= src_n;
    end
  end
endmodule

// File: rtl/cif_coissue_checker.sv
module cif_coissue_checker #(
  parameter int WARPS = 16,
  parameter int LANES = 16,
  parameter int WAYS  = 4,
  localparam int WID_W = $clog2(WARPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WARPS-1:0] ready_i,
  input logic             prim_valid_i,
  input logic [WID_W-1:0] prim_wid_i,
  input logic             issue_valid_o,
  input logic             sec_valid_o,
  input logic [WID_W-1:0] sec_wid_o,
  input logic [LANES-1:0] lane_en_o,
  input logic [LANES-1:0] lane_src_o
);
  // R10: no request, quiet outputs next cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_valid_i |=> (!issue_valid_o && !sec_valid_o && lane_en_o == '0));

  // R4: partner comes from the primary's group
  a_r4_same_group: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid_i |=> (!sec_valid_o || (int'(sec_wid_o) / WAYS) == (int'($past(prim_wid_i)) / WAYS)));

  // R5: partner is never the primary itself
  a_r5_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid_i |=> (!sec_valid_o || sec_wid_o != $past(prim_wid_i)));

  // R5: partner was ready when searched
  a_r5_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid_i |=> (!sec_valid_o || ((($past(ready_i)) >> sec_wid_o) & WARPS'(1)) != '0));

  // R8: secondary lanes are a subset of enabled lanes
  a_r8_src_in_en: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_src_o & ~lane_en_o) == '0);

  // R7: no partner, no secondary lanes
  a_r7_no_src: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_valid_o |-> (lane_src_o == '0 && sec_wid_o == '0));
endmodule

bind cif_coissue_finder cif_coissue_checker #(
  .WARPS(WARPS), .LANES(LANES), .WAYS(WAYS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ready_i       (ready_i),
  .prim_valid_i  (prim_valid_i),
  .prim_wid_i    (prim_wid_i),
  .issue_valid_o (issue_valid_o),
  .sec_valid_o   (sec_valid_o),
  .sec_wid_o     (sec_wid_o),
  .lane_en_o     (lane_en_o),
  .lane_src_o    (lane_src_o)
);

// File: tb/cif_coissue_finder_test.sv
module cif_coissue_finder_test;
  localparam int WARPS = 16;
  localparam int LANES = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en_i;
  logic [3:0]       wr_wid_i;
  logic [15:0]      wr_mask_i;
  logic [15:0]      ready_i;
  logic             prim_valid_i;
  logic [3:0]       prim_wid_i;
  logic [15:0]      prim_mask_i;
  logic             issue_valid_o, sec_valid_o;
  logic [3:0]       sec_wid_o;
  logic [15:0]      lane_en_o, lane_src_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lmask [WARPS];

  always #10 clk = ~clk;

  cif_coissue_finder uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_wid_i(wr_wid_i),
    .wr_mask_i(wr_mask_i), .ready_i(ready_i), .prim_valid_i(prim_valid_i),
    .prim_wid_i(prim_wid_i), .prim_mask_i(prim_mask_i),
    .issue_valid_o(issue_valid_o), .sec_valid_o(sec_valid_o),
    .sec_wid_o(sec_wid_o), .lane_en_o(lane_en_o), .lane_src_o(lane_src_o)
  );

  function automatic logic [15:0] rot(input logic [15:0] m, input int w);
    logic [15:0] r = '0;
    for (int t = 0; t < LANES; t++) r[(t + w) % LANES] = m[t];
    return r;
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [15:0] m);
    @(negedge clk);
    wr_en_i = 1'b1; wr_wid_i = 4'(w); wr_mask_i = m;
    @(negedge clk);
    wr_en_i = 1'b0;
    lmask[w] = m;
  endtask

  // one search; outputs sampled on the negedge after the capturing edge
  task automatic search(input string req, input int pw, input logic [15:0] pm,
                        input bit exp_hit, input int exp_wid);
    logic [15:0] pp, sp;
    pp = rot(pm, pw);
    sp = exp_hit ? rot(lmask[exp_wid], exp_wid) : 16'h0;
    prim_valid_i = 1'b1; prim_wid_i = 4'(pw); prim_mask_i = pm;
    @(negedge clk);
    prim_valid_i = 1'b0;
    cmp(req, "issue_valid", int'(issue_valid_o), 1);
    cmp(req, "sec_valid", int'(sec_valid_o), int'(exp_hit));
    cmp(req, "sec_wid", int'(sec_wid_o), exp_hit ? exp_wid : 0);
    cmp(req, "lane_en", int'(lane_en_o), int'(pp | sp));
    cmp(req, "lane_src", int'(lane_src_o), int'(sp));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en_i = 0; wr_wid_i = 0; wr_mask_i = 0; ready_i = 0;
    prim_valid_i = 0; prim_wid_i = 0; prim_mask_i = 0;
    for (int w = 0; w < WARPS; w++) lmask[w] = '0;
    #35;
    cmp("R1", "lane_en in reset", int'(lane_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    cmp("R1", "issue_valid", int'(issue_valid_o), 0);
    cmp("R1", "sec_valid", int'(sec_valid_o), 0);
    cmp("R1", "lane_src", int'(lane_src_o), 0);
  endtask

  task automatic t_pair;   // R3 R8
    wr(1, 16'h00F0);
    ready_i = 16'h0002;
    search("R8", 0, 16'h000F, 1, 1);
    cmp("R8", "merged lanes", int'(lane_en_o), 16'h01EF);
  endtask

  task automatic t_overlap; // R3 R7: lane 5 shared
    search("R3", 0, 16'h0020, 0, 0);
    cmp("R7", "primary only lanes", int'(lane_en_o), 16'h0020);
  endtask

  task automatic t_rotation; // R2: same logical mask, different lanes
    wr(5, 16'h0001);
    ready_i = 16'h0020;
    search("R2", 4, 16'h0001, 1, 5);
    cmp("R2", "rotated lanes", int'(lane_en_o), 16'h0030);
  endtask

  task automatic t_group; // R4
    wr(8, 16'h0000);
    ready_i = 16'h0100;
    search("R4", 0, 16'h0001, 0, 0);
    search("R4", 9, 16'h0001, 1, 8);
  endtask

  task automatic t_exclude; // R5
    wr(2, 16'h0000);
    wr(3, 16'h0000);
    ready_i = 16'h0004;           // only the primary itself
    search("R5", 2, 16'h0003, 0, 0);
    ready_i = 16'h0000;           // idle warp 3 not ready
    search("R5", 2, 16'h0003, 0, 0);
    ready_i = 16'h000C;
    search("R5", 2, 16'h0003, 1, 3);
  endtask

  task automatic t_priority; // R6
    wr(13, 16'h0000); wr(14, 16'h0000); wr(15, 16'h0000);
    ready_i = 16'hE000;
    search("R6", 12, 16'h00FF, 1, 13);
    ready_i = 16'hF000;
    search("R6", 15, 16'h00FF, 1, 12);
  endtask

  task automatic t_idle; // R10
    @(negedge clk);
    cmp("R10", "issue_valid", int'(issue_valid_o), 0);
    cmp("R10", "lane_en", int'(lane_en_o), 0);
  endtask

  task automatic t_write_timing; // R9
    ready_i = 16'h0002;
    wr_en_i = 1'b1; wr_wid_i = 4'd1; wr_mask_i = 16'h0001; // phys 0x0002, conflicts
    search("R9", 0, 16'h000F, 1, 1);   // still sees 0x00F0
    wr_en_i = 1'b0;
    lmask[1] = 16'h0001;
    search("R9", 0, 16'h000F, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pair();
    t_overlap();
    t_rotation();
    t_group();
    t_exclude();
    t_priority();
    t_idle();
    t_write_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule